// File: doc/BRIEF.md
# Transport-Triggered Arithmetic Function Unit

This block is one function unit of a processor whose program moves data between units instead of naming operations. The unit has two writable input ports and three result registers. A write to the plain operand port only stores a value. A write to the trigger port stores the second operand and, in the same cycle, launches the operation named by the opcode that travels with that write. Nothing else starts a computation.

Each operation has a fixed latency that software must respect. There is no interlock, stall or hazard detection. Reading a result register too early returns whatever the previous operation of that kind left there. A result that is not read before the next operation of the same kind completes is overwritten. Add, subtract and the combined add/subtract finish after one cycle into two ALU result registers. Multiply finishes after three cycles into a result register of its own. The pipeline accepts a trigger on every clock.

Top module: `tt_fu`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation completes, all three result registers (`alu_res1`, `alu_res2`, `mul_res`) read 0.
- R2: A cycle with `opnd_we` high and `trig_we` low changes no result register. The stored value becomes the first operand of later triggers.
- R3: A trigger with opcode 2'b00 (add) makes `alu_res1` equal to first operand plus `trig_data` in the cycle after the trigger. `alu_res2` keeps its value.
- R4: A trigger with opcode 2'b01 (subtract) makes `alu_res1` equal to first operand minus `trig_data`, modulo 2^W, in the cycle after the trigger. `alu_res2` keeps its value.
- R5: A trigger with opcode 2'b11 (add/subtract) puts the difference (first operand minus `trig_data`) on `alu_res1` and the sum on `alu_res2`, both in the cycle after the trigger.
- R6: A trigger with opcode 2'b10 (multiply) makes `mul_res` equal to the low W bits of the product in the third cycle after the trigger. In the two cycles in between, `mul_res` still shows the previous multiply result.
- R7: A trigger is accepted on every cycle, including while multiplies are in flight. Each completing operation overwrites its result register, so a result that was not read is lost.
- R8: A multiply never changes `alu_res1`/`alu_res2`, and ALU operations never change `mul_res`. This also holds when an ALU result and a multiply result complete on the same edge.
- R9: When `opnd_we` and `trig_we` are both high in one cycle, the trigger uses the value written on `opnd_data` in that cycle as its first operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_we | input | 1 | Write strobe of the plain operand port |
| opnd_data | input | W | Value written to the operand port |
| trig_we | input | 1 | Write strobe of the trigger port |
| trig_op | input | 2 | Opcode: 00 add, 01 sub, 10 mul, 11 add/subtract |
| trig_data | input | W | Second operand carried by the trigger write |
| alu_res1 | output | W | Sum, difference, or add/subtract difference |
| alu_res2 | output | W | Sum of the add/subtract operation |
| mul_res | output | W | Low W bits of the product |

## Verification
The assertions check the following on every cycle:
- the one-cycle ALU results, for each opcode and with same-cycle operand forwarding;
- that the result registers hold their values when no trigger of their kind was issued;
- that `mul_res` changes only on the edge where a multiply issued two cycles earlier completes.

Only the bench's scenarios can show these:
- the multiply values themselves;
- the stale value visible during the latency window;
- the loss of unread results when triggers arrive back to back;
- the same-edge completion of an add and a multiply.

// File: rtl/tt_fu_pkg.sv
package tt_fu_pkg;
    typedef enum logic [1:0] {
        OP_ADD    = 2'b00,
        OP_SUB    = 2'b01,
        OP_MUL    = 2'b10,
        OP_ADDSUB = 2'b11
    } fu_op_e;
endpackage

// File: rtl/tt_fu_opnd_latch.sv
module tt_fu_opnd_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] din,
    output logic [W-1:0] held,
    output logic [W-1:0] eff
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (we) begin
            held <= din;
        end
    end

    // same-cycle write is forwarded to a trigger in that cycle
    always_comb begin
        eff = we ? din : held;
    end
endmodule

// File: rtl/tt_fu_alu.sv
module tt_fu_alu
    import tt_fu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  fu_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res1,
    output logic [W-1:0] res2
);
    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         ld1;
    logic         ld2;
    logic [W-1:0] nxt1;

    always_comb begin
        sum  = a + b;
        diff = a - b;
        ld1  = 1'b0;
        ld2  = 1'b0;
        nxt1 = sum;
        if (fire) begin
            unique case (op)
                OP_ADD:    begin ld1 = 1'b1; nxt1 = sum;  end
                OP_SUB:    begin ld1 = 1'b1; nxt1 = diff; end
                OP_ADDSUB: begin ld1 = 1'b1; ld2 = 1'b1; nxt1 = diff; end
                default:   begin ld1 = 1'b0; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res1 <= '0;
            res2 <= '0;
        end else begin
            if (ld1) res1 <= nxt1;
            if (ld2) res2 <= sum;
        end
    end
endmodule

// File: rtl/tt_fu_mul.sv
module tt_fu_mul #(
    parameter int W   = 32,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    localparam int STG = LAT - 1;

    logic [W-1:0] prod;
    logic [W-1:0] pv  [STG];
    logic         vld [STG];

    always_comb begin
        prod = a * b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv[0]  <= '0;
            vld[0] <= 1'b0;
        end else begin
            pv[0]  <= prod;
            vld[0] <= fire;
        end
    end

    genvar gi;
    generate
        for (gi = 1; gi < STG; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pv[gi]  <= '0;
                    vld[gi] <= 1'b0;
                end else begin
                    pv[gi]  <= pv[gi-1];
                    vld[gi] <= vld[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res <= '0;
        end else if (vld[STG-1]) begin
            res <= pv[STG-1];
        end
    end
endmodule

// File: rtl/tt_fu.sv
module tt_fu
    import tt_fu_pkg::*;
#(
    parameter int W       = 32,
    parameter int MUL_LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         opnd_we,
    input  logic [W-1:0] opnd_data,
    input  logic         trig_we,
    input  logic [1:0]   trig_op,
    input  logic [W-1:0] trig_data,
    output logic [W-1:0] alu_res1,
    output logic [W-1:0] alu_res2,
    output logic [W-1:0] mul_res
);
    fu_op_e       op;
    logic [W-1:0] opnd_held;
    logic [W-1:0] opnd_eff;
    logic         alu_fire;
    logic         mul_fire;

    always_comb begin
        op       = fu_op_e'(trig_op);
        mul_fire = trig_we && (op == OP_MUL);
        alu_fire = trig_we && (op != OP_MUL);
    end

    tt_fu_opnd_latch #(.W(W)) u_opnd (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (opnd_we),
        .din  (opnd_data),
        .held (opnd_held),
        .eff  (opnd_eff)
    );

    tt_fu_alu #(.W(W)) u_alu (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (alu_fire),
        .op   (op),
        .a    (opnd_eff),
        .b    (trig_data),
        .res1 (alu_res1),
        .res2 (alu_res2)
    );

    tt_fu_mul #(.W(W), .LAT(MUL_LAT)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (mul_fire),
        .a    (opnd_eff),
        .b    (trig_data),
        .res  (mul_res)
    );
endmodule

// File: rtl/tt_fu_chk.sv
module tt_fu_chk #(
    parameter int W       = 32,
    parameter int MUL_LAT = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         opnd_we,
    input logic [W-1:0] opnd_data,
    input logic         trig_we,
    input logic [1:0]   trig_op,
    input logic [W-1:0] trig_data,
    input logic [W-1:0] opnd_held,
    input logic [W-1:0] alu_res1,
    input logic [W-1:0] alu_res2,
    input logic [W-1:0] mul_res
);
    localparam int SH = MUL_LAT - 1;

    logic [W-1:0] a_in;
    logic [SH-1:0] mul_sh;

    always_comb a_in = opnd_we ? opnd_data : opnd_held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mul_sh <= '0;
        else        mul_sh <= {mul_sh[SH-2:0], trig_we && (trig_op == 2'b10)};
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_zero_R1: assert (alu_res1 == '0 && alu_res2 == '0 && mul_res == '0);
        end
    end

    assert_opnd_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_we |=> ($stable(alu_res1) && $stable(alu_res2)));

    assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && trig_op == 2'b00) |=>
            (alu_res1 == $past(a_in + trig_data)) && $stable(alu_res2));

    assert_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && trig_op == 2'b01) |=>
            (alu_res1 == $past(a_in - trig_data)) && $stable(alu_res2));

    assert_addsub_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && trig_op == 2'b11) |=>
            (alu_res1 == $past(a_in - trig_data)) && (alu_res2 == $past(a_in + trig_data)));

    assert_mul_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mul_sh[SH-1] |=> $stable(mul_res));

    assert_mul_no_alu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && trig_op == 2'b10) |=> ($stable(alu_res1) && $stable(alu_res2)));
endmodule

bind tt_fu tt_fu_chk #(.W(W), .MUL_LAT(MUL_LAT)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_we  (opnd_we),
    .opnd_data(opnd_data),
    .trig_we  (trig_we),
    .trig_op  (trig_op),
    .trig_data(trig_data),
    .opnd_held(opnd_held),
    .alu_res1 (alu_res1),
    .alu_res2 (alu_res2),
    .mul_res  (mul_res)
);

// File: tb/test_tt_fu.sv
module test_tt_fu;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         opnd_we;
    logic [W-1:0] opnd_data;
    logic         trig_we;
    logic [1:0]   trig_op;
    logic [W-1:0] trig_data;
    logic [W-1:0] alu_res1, alu_res2, mul_res;

    always #10 clk = ~clk;

    tt_fu #(.W(W), .MUL_LAT(3)) i_tt_fu (
        .clk(clk), .rst_n(rst_n),
        .opnd_we(opnd_we), .opnd_data(opnd_data),
        .trig_we(trig_we), .trig_op(trig_op), .trig_data(trig_data),
        .alu_res1(alu_res1), .alu_res2(alu_res2), .mul_res(mul_res)
    );

    int    total = 0;
    int    bad   = 0;
    string tag   = "R1";
    bit    cmp_on = 1'b0;

    task automatic chk(string r, string nm, logic [W-1:0] got, logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", r, nm, got, exp);
        end
    endtask

    // behavioural reference model
    logic [W-1:0] m_held = '0, m_r1 = '0, m_r2 = '0, m_mul = '0;
    int           cyc = 0;
    int           due_q[$];
    logic [W-1:0] val_q[$];

    always @(posedge clk) begin
        logic [W-1:0] a;
        if (!rst_n) begin
            m_held = '0; m_r1 = '0; m_r2 = '0; m_mul = '0;
            due_q.delete(); val_q.delete();
        end else begin
            cyc++;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                m_mul = val_q.pop_front();
                void'(due_q.pop_front());
            end
            a = opnd_we ? opnd_data : m_held;
            if (trig_we) begin
                case (trig_op)
                    2'b00: m_r1 = a + trig_data;
                    2'b01: m_r1 = a - trig_data;
                    2'b11: begin m_r1 = a - trig_data; m_r2 = a + trig_data; end
                    default: begin due_q.push_back(cyc + 2); val_q.push_back(a * trig_data); end
                endcase
            end
            if (opnd_we) m_held = opnd_data;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(tag, "alu_res1", alu_res1, m_r1);
            chk(tag, "alu_res2", alu_res2, m_r2);
            chk(tag, "mul_res",  mul_res,  m_mul);
        end
    end

    task automatic drive(bit ow, logic [W-1:0] od, bit tw, logic [1:0] op, logic [W-1:0] td);
        @(negedge clk);
        opnd_we = ow; opnd_data = od; trig_we = tw; trig_op = op; trig_data = td;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, '0, 0, 2'b00, '0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        opnd_we = 0; opnd_data = '0; trig_we = 0; trig_op = 2'b00; trig_data = '0;
        repeat (3) @(negedge clk);
        chk("R1", "alu_res1 in reset", alu_res1, '0);
        chk("R1", "alu_res2 in reset", alu_res2, '0);
        chk("R1", "mul_res in reset",  mul_res,  '0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(2);

        tag = "R2";                       // operand write alone
        drive(1, 32'd1234, 0, 2'b00, '0);
        drive(1, 32'd17, 0, 2'b11, 32'd99);
        idle(2);

        tag = "R3";                       // add uses stored 17
        drive(0, '0, 1, 2'b00, 32'd25);
        idle(1);
        chk("R3", "add result direct", alu_res1, 32'd42);
        drive(1, 32'hFFFF_FFFF, 1, 2'b00, 32'd2);   // wraparound
        idle(2);

        tag = "R4";
        drive(1, 32'd3, 0, 2'b00, '0);
        drive(0, '0, 1, 2'b01, 32'd5);
        idle(1);
        chk("R4", "sub wrap direct", alu_res1, 32'hFFFF_FFFE);
        idle(1);

        tag = "R5";
        drive(1, 32'd100, 1, 2'b11, 32'd30);
        idle(1);
        chk("R5", "addsub diff", alu_res1, 32'd70);
        chk("R5", "addsub sum",  alu_res2, 32'd130);
        idle(1);

        tag = "R6";                       // mul latency 3
        drive(1, 32'd7, 1, 2'b10, 32'd6);
        idle(1);
        chk("R6", "mul stale +1", mul_res, 32'd0);
        idle(1);
        chk("R6", "mul stale +2", mul_res, 32'd0);
        idle(1);
        chk("R6", "mul ready +3", mul_res, 32'd42);
        drive(1, 32'h1_0001, 1, 2'b10, 32'h1_0001);   // low half of product
        idle(4);

        tag = "R7";                       // back-to-back, overwrite
        drive(1, 32'd2, 1, 2'b10, 32'd3);
        drive(0, '0, 1, 2'b10, 32'd5);
        drive(0, '0, 1, 2'b00, 32'd1);
        drive(0, '0, 1, 2'b00, 32'd8);
        drive(0, '0, 1, 2'b10, 32'd11);
        idle(1);
        chk("R7", "add overwritten", alu_res1, 32'd10);
        idle(3);

        tag = "R8";                       // mul and add complete on same edge
        drive(1, 32'd9, 1, 2'b10, 32'd9);
        idle(1);
        drive(0, '0, 1, 2'b11, 32'd4);
        idle(1);
        chk("R8", "mul same edge",   mul_res,  32'd81);
        chk("R8", "alu1 same edge",  alu_res1, 32'd5);
        chk("R8", "alu2 same edge",  alu_res2, 32'd13);
        idle(2);

        tag = "R9";                       // forwarding of same-cycle operand
        drive(1, 32'd50, 0, 2'b00, '0);
        drive(1, 32'd200, 1, 2'b01, 32'd1);
        idle(1);
        chk("R9", "forwarded operand", alu_res1, 32'd199);
        idle(1);

        tag = "R7";                       // mixed traffic
        for (int i = 0; i < 300; i++) begin
            drive($urandom_range(0, 1), $urandom, $urandom_range(0, 1),
                  2'($urandom_range(0, 3)), $urandom);
        end
        idle(5);
        summary();
    end
endmodule